// File: doc/BRIEF.md
# Triggered Event Memory Sequencer

This block steers self-triggered acquisition into a small column memory shared by a set of detector channels. While the acquisition input is held high, every new trigger (the OR of all channel discriminators going from low to high) claims the next free column. The block stores in that column which channels were firing and the value of a bunch-crossing counter. The counter restarts at zero when acquisition starts and advances once per acquiring clock.

Once every column is used, the block raises a full flag and refuses further writes. When acquisition ends with nothing stored, it raises a no-event flag. It drives a one-hot column select and a one-cycle hold strobe for the analog sample memory. Conversion and readout stages get a count of filled columns and a read port into the stored hit patterns and timestamps.

Top module: `evt_mem_seq`

## Requirements
- R1: After reset, fillCount is 0 and ramFull, noTrig, holdOut and colSel are all 0.
- R2: The first clock with startAcq high after it was low starts an acquisition. It clears fillCount, ramFull and noTrig, restarts the timestamp at 0, and clears the hit pattern of every column to zero.
- R3: While acquiring, a clock in which the OR of chanTrig goes from 0 to 1 writes the chanTrig vector of that cycle into column fillCount and raises fillCount by one. Bit i of rdHits is channel i.
- R4: The timestamp stored with a write equals the number of acquiring clocks that came before the trigger clock. The first clock after the start clock counts as 0.
- R5: While the OR of chanTrig stays high, including when different channels take over, no further column is used.
- R6: After DEPTH writes, ramFull is 1 and stays 1 until the next start. Further trigger edges leave fillCount at DEPTH and leave column 0 unchanged.
- R7: When startAcq falls, noTrig becomes 1 if fillCount is 0 and stays 0 otherwise. It holds that value until the next start.
- R8: Trigger edges while startAcq is low change neither fillCount nor the memory.
- R9: colSel is one-hot at bit fillCount while acquiring and not full, and all zero otherwise.
- R10: holdOut is 1 for exactly the one clock that follows each write.
- R11: The timestamp is BCID_W bits wide and wraps modulo 2^BCID_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startAcq | input | 1 | Acquisition window, active high |
| chanTrig | input | NUM_CH | Per-channel discriminator outputs |
| rdCol | input | COL_W | Column to read back |
| ramFull | output | 1 | All columns occupied |
| noTrig | output | 1 | Last acquisition stored no event |
| fillCount | output | CNT_W | Number of filled columns, 0 to DEPTH |
| holdOut | output | 1 | Hold strobe for the analog memory |
| colSel | output | DEPTH | One-hot select of the column to be written next |
| rdHits | output | NUM_CH | Hit pattern of column rdCol |
| rdBcid | output | BCID_W | Timestamp of column rdCol |

## Verification
The bench builds the block with its default parameters: 36 channels, 16 columns and an 8-bit timestamp. With 16 columns, the full-memory lockout is reached after a few dozen clocks, so the ignored write beyond the last column can be checked by reading column 0 back. The 8-bit timestamp wraps after 256 acquiring clocks, so a trigger placed after 300 idle clocks exposes the modulo behaviour.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  typedef struct packed {
    logic clearAll;
    logic writeEn;
    logic tick;
  } seq_strobe_t;
endpackage

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl #(
  parameter int DEPTH = 16,
  parameter int COL_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      startAcq,
  input  logic                      trigAny,
  output evt_seq_pkg::seq_strobe_t  strb,
  output logic [COL_W-1:0]          wrCol,
  output logic [CNT_W-1:0]          fillCount,
  output logic                      ramFull,
  output logic                      noTrig,
  output logic                      holdOut,
  output logic                      acqActive
);
  logic acqOn;
  logic trigPrev;
  logic startPulse;
  logic stopPulse;
  logic trigEdge;
  logic wrEn;

  assign startPulse = startAcq & ~acqOn;
  assign stopPulse  = ~startAcq & acqOn;
  assign trigEdge   = trigAny & ~trigPrev;
  assign acqActive  = acqOn & startAcq;
  assign wrEn       = acqActive & trigEdge & ~ramFull;

  assign strb.clearAll = startPulse;
  assign strb.writeEn  = wrEn;
  assign strb.tick     = acqActive;
  assign wrCol         = fillCount[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acqOn    <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      acqOn    <= startAcq;
      trigPrev <= trigAny;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fillCount <= '0;
      ramFull   <= 1'b0;
      noTrig    <= 1'b0;
      holdOut   <= 1'b0;
    end else begin
      holdOut <= wrEn;
      if (startPulse) begin
        fillCount <= '0;
        ramFull   <= 1'b0;
        noTrig    <= 1'b0;
      end else begin
        if (wrEn) begin
          fillCount <= fillCount + 1'b1;
          if (fillCount == CNT_W'(DEPTH - 1)) ramFull <= 1'b1;
        end
        if (stopPulse) noTrig <= (fillCount == '0);
      end
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fillCount <= CNT_W'(DEPTH));
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !startPulse |=> (fillCount == $past(fillCount)) || (fillCount == $past(fillCount) + 1'b1));
  a_r10_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> holdOut);
  a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ramFull && !startPulse) |=> ramFull);
  a_r7_notrig_empty: assert property (@(posedge clk) disable iff (!rst_n)
    noTrig |-> (fillCount == '0));
  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!startAcq && !startPulse) |=> (fillCount == $past(fillCount)));
endmodule

// File: rtl/evt_seq_datapath.sv
module evt_seq_datapath #(
  parameter int NUM_CH = 36,
  parameter int DEPTH  = 16,
  parameter int BCID_W = 8,
  parameter int COL_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  evt_seq_pkg::seq_strobe_t  strb,
  input  logic [COL_W-1:0]          wrCol,
  input  logic                      acqActive,
  input  logic                      ramFull,
  input  logic [NUM_CH-1:0]         chanTrig,
  input  logic [COL_W-1:0]          rdCol,
  output logic [DEPTH-1:0]          colSel,
  output logic [NUM_CH-1:0]         rdHits,
  output logic [BCID_W-1:0]         rdBcid
);
  logic [BCID_W-1:0] bcidCnt;
  logic [NUM_CH-1:0] hitMem  [DEPTH];
  logic [BCID_W-1:0] bcidMem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             bcidCnt <= '0;
    else if (strb.clearAll) bcidCnt <= '0;
    else if (strb.tick)     bcidCnt <= bcidCnt + 1'b1;
  end

  for (genvar c = 0; c < DEPTH; c++) begin : g_col
    logic hitHere;
    assign hitHere   = strb.writeEn && (wrCol == COL_W'(c));
    assign colSel[c] = acqActive && !ramFull && (wrCol == COL_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hitMem[c]  <= '0;
        bcidMem[c] <= '0;
      end else if (strb.clearAll) begin
        hitMem[c]  <= '0;
        bcidMem[c] <= '0;
      end else if (hitHere) begin
        hitMem[c]  <= chanTrig;
        bcidMem[c] <= bcidCnt;
      end
    end
  end

  assign rdHits = hitMem[rdCol];
  assign rdBcid = bcidMem[rdCol];

  a_r9_colsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(colSel));
  a_r9_colsel_quiet_full: assert property (@(posedge clk) disable iff (!rst_n)
    ramFull |-> (colSel == '0));
  a_r11_bcid_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.tick && !strb.clearAll) |=> (bcidCnt == $past(bcidCnt) + 1'b1));
endmodule

// File: rtl/evt_mem_seq.sv
module evt_mem_seq #(
  parameter int NUM_CH = 36,
  parameter int DEPTH  = 16,
  parameter int BCID_W = 8,
  localparam int COL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startAcq,
  input  logic [NUM_CH-1:0] chanTrig,
  input  logic [COL_W-1:0]  rdCol,
  output logic              ramFull,
  output logic              noTrig,
  output logic [CNT_W-1:0]  fillCount,
  output logic              holdOut,
  output logic [DEPTH-1:0]  colSel,
  output logic [NUM_CH-1:0] rdHits,
  output logic [BCID_W-1:0] rdBcid
);
  evt_seq_pkg::seq_strobe_t strb;
  logic [COL_W-1:0] wrCol;
  logic             acqActive;

  evt_seq_ctrl #(.DEPTH(DEPTH), .COL_W(COL_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startAcq(startAcq), .trigAny(|chanTrig),
    .strb(strb), .wrCol(wrCol), .fillCount(fillCount), .ramFull(ramFull),
    .noTrig(noTrig), .holdOut(holdOut), .acqActive(acqActive)
  );

  evt_seq_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .BCID_W(BCID_W), .COL_W(COL_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrCol(wrCol), .acqActive(acqActive),
    .ramFull(ramFull), .chanTrig(chanTrig), .rdCol(rdCol), .colSel(colSel),
    .rdHits(rdHits), .rdBcid(rdBcid)
  );
endmodule

// File: tb/evt_mem_seq_tb.sv
module evt_mem_seq_tb_top;
  localparam int NCH = 36;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startAcq = 1'b0;
  logic [NCH-1:0] chanTrig = '0;
  logic [3:0] rdCol = '0;
  logic ramFull, noTrig, holdOut;
  logic [4:0] fillCount;
  logic [DEP-1:0] colSel;
  logic [NCH-1:0] rdHits;
  logic [7:0] rdBcid;

  int nChecks = 0;
  int nFails = 0;
  int acqCyc = 0;

  always #4 clk = ~clk;

  evt_mem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .startAcq(startAcq), .chanTrig(chanTrig), .rdCol(rdCol),
    .ramFull(ramFull), .noTrig(noTrig), .fillCount(fillCount), .holdOut(holdOut),
    .colSel(colSel), .rdHits(rdHits), .rdBcid(rdBcid)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (startAcq) acqCyc++;
  endtask

  function automatic logic [NCH-1:0] pat(int i);
    logic [63:0] v;
    v = 64'h9E3779B97F4A7C15 * 64'(i + 1);
    return NCH'(v) | NCH'(1);
  endfunction

  task automatic begin_acq();
    startAcq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acqCyc = 0;
  endtask

  task automatic end_acq();
    startAcq = 1'b0;
    step();
  endtask

  task automatic pulse(logic [NCH-1:0] p);
    chanTrig = p;
    step();
    chanTrig = '0;
  endtask

  task automatic t_reset();
    check("R1 fillCount", 64'(fillCount), 0);
    check("R1 ramFull", 64'(ramFull), 0);
    check("R1 noTrig", 64'(noTrig), 0);
    check("R1 holdOut", 64'(holdOut), 0);
    check("R1 colSel", 64'(colSel), 0);
  endtask

  task automatic t_basic();
    int stamps[3];
    begin_acq();
    check("R2 count after start", 64'(fillCount), 0);
    check("R9 colSel col0", 64'(colSel), 64'h1);
    step(); step();
    stamps[0] = acqCyc;
    pulse(pat(0));
    check("R10 hold after write", 64'(holdOut), 1);
    check("R3 count 1", 64'(fillCount), 1);
    check("R9 colSel col1", 64'(colSel), 64'h2);
    step();
    check("R10 hold one cycle", 64'(holdOut), 0);
    for (int k = 0; k < 4; k++) step();
    stamps[1] = acqCyc;
    pulse(pat(1));
    step();
    stamps[2] = acqCyc;
    pulse(36'h8_0000_0001);
    check("R3 count 3", 64'(fillCount), 3);
    for (int i = 0; i < 3; i++) begin
      rdCol = 4'(i);
      #1;
      check("R3 hits", 64'(rdHits), 64'(i == 2 ? 36'h8_0000_0001 : pat(i)));
      check("R4 stamp", 64'(rdBcid), 64'(stamps[i]));
    end
    end_acq();
    check("R7 noTrig low with events", 64'(noTrig), 0);
    check("R9 colSel idle", 64'(colSel), 0);
  endtask

  task automatic t_held();
    begin_acq();
    rdCol = 4'd0;
    #1;
    check("R2 hits cleared on start", 64'(rdHits), 0);
    chanTrig = 36'h1;
    step();
    chanTrig = 36'h3;
    step();
    chanTrig = 36'h2;
    step(); step();
    check("R5 held trigger one write", 64'(fillCount), 1);
    check("R5 first pattern kept", 64'(rdHits), 64'h1);
    chanTrig = '0;
    step();
    pulse(36'h4);
    check("R5 new edge writes", 64'(fillCount), 2);
    end_acq();
  endtask

  task automatic t_idle();
    pulse(36'hF);
    step();
    check("R8 idle trig count", 64'(fillCount), 2);
    rdCol = 4'd2;
    #1;
    check("R8 idle trig memory", 64'(rdHits), 0);
  endtask

  task automatic t_full();
    begin_acq();
    for (int i = 0; i < DEP; i++) begin
      pulse(pat(i + 10));
      step();
    end
    check("R6 full count", 64'(fillCount), DEP);
    check("R6 ramFull", 64'(ramFull), 1);
    check("R9 colSel when full", 64'(colSel), 0);
    pulse(36'hFFFF);
    check("R6 no hold when full", 64'(holdOut), 0);
    step();
    check("R6 count stays", 64'(fillCount), DEP);
    rdCol = 4'd0;
    #1;
    check("R6 col0 kept", 64'(rdHits), 64'(pat(10)));
    rdCol = 4'd15;
    #1;
    check("R3 last col", 64'(rdHits), 64'(pat(25)));
    end_acq();
    check("R6 full after end", 64'(ramFull), 1);
    begin_acq();
    check("R2 full cleared", 64'(ramFull), 0);
  endtask

  task automatic t_empty();
    step(); step();
    end_acq();
    check("R7 noTrig set", 64'(noTrig), 1);
    step();
    check("R7 noTrig held", 64'(noTrig), 1);
    begin_acq();
    check("R2 noTrig cleared", 64'(noTrig), 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 300; k++) step();
    pulse(36'h5);
    rdCol = 4'd0;
    #1;
    check("R11 wrapped stamp", 64'(rdBcid), 64'(300 % 256));
    end_acq();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_held();
        t_idle();
        t_full();
        t_empty();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule